// File: doc/BRIEF.md
# Deserializer Alignment Lock Sequencer

This block runs in the slow parallel clock domain of a serial receiver channel. It decides when the phase-alignment logic may report lock after reset. Each slow-clock cycle it may receive one deserialized word. It rebuilds the serial bit order, least significant bit first, and counts every change of level between neighbouring serial bits. That count includes the change between the last bit of the previous accepted word and the first bit of the current one.

Two lock sequences are available. In the plain sequence, lock follows as soon as one counting phase has seen the target number of transitions. In the calibration sequence, three counting phases alternate with two quiet windows. Each quiet window lasts a fixed number of slow-clock cycles and ignores the data. The locked output is sticky until reset. Every channel uses its own instance, so channels count independently.

Top module: `align_lock_seq`

## Requirements
- R1: Transitions are counted over the serial stream with bit 0 of a word sent first. Bit 0 is compared with the last bit of the previous accepted word, and with 0 for the first word after reset. `transCount` shows the running total of the current counting phase one cycle after the word is presented.
- R2: A word presented with `dataValid` low neither adds transitions nor replaces the stored last bit.
- R3: If the sequence follows the plain path, `phase` moves from 0 directly to 5 in the cycle the first counting phase reaches TARGET (default 256) transitions.
- R4: The phase codes are 0 count, 1 quiet, 2 count, 3 quiet, 4 count and 5 locked. The calibration sequence visits them in that order, and a phase only ever steps forward.
- R5: Each quiet phase (codes 1 and 3) lasts exactly IDLE_CYCLES slow-clock cycles (default 96). Its length does not depend on the data or on `dataValid`.
- R6: A counting phase ends in the cycle its total reaches or passes TARGET. Transitions beyond the target in that word are discarded, so the next counting phase starts from 0.
- R7: `calEn` is sampled only in the cycle the first counting phase completes. High selects the calibration sequence and low selects the plain one. Later changes have no effect.
- R8: `locked` is high exactly in phase 5. Once high, it stays high until reset, whatever the data.
- R9: While reset (`rstN` low, synchronous) is applied, `locked` is 0, `phase` is 0 and `transCount` is 0, and the stored last bit is cleared.
- R10: `transCount` is always below TARGET, and it is 0 during the quiet and locked phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow parallel clock |
| rstN | input | 1 | Synchronous active-low reset |
| dataWord | input | WORD_W | Deserialized word, bit 0 first on the line |
| dataValid | input | 1 | Word qualifier |
| calEn | input | 1 | Selects the calibration sequence |
| locked | output | 1 | Sticky lock indication |
| phase | output | 3 | Current sequence phase code |
| transCount | output | $clog2(TARGET+1) | Transitions counted in the current phase |

## Verification
A wrong stored last bit shows in `transCount` as an off-by-one on the very next valid word. A faulty saturation or phase step shows as a `phase` code that is early, late or out of order in the cycle the target is crossed. A wrong quiet-window counter moves the return to a counting phase by at least one cycle. Because of that, comparing all three outputs against a behavioural model on every cycle exposes such a fault within one cycle of its first effect.

// File: rtl/align_lock_pkg.sv
package align_lock_pkg;
  typedef enum logic [2:0] {
    PH_TRAIN0 = 3'd0,
    PH_QUIET0 = 3'd1,
    PH_TRAIN1 = 3'd2,
    PH_QUIET1 = 3'd3,
    PH_TRAIN2 = 3'd4,
    PH_LOCKED = 3'd5
  } phase_e;

  typedef struct packed {
    logic countEn;
    logic idleEn;
  } seq_strobe_t;
endpackage

// File: rtl/align_lock_dp.sv
module align_lock_dp
  import align_lock_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int TARGET = 256,
  parameter int IDLE_CYCLES = 96,
  localparam int CNT_W = $clog2(TARGET + 1),
  localparam int EDGE_W = $clog2(WORD_W + 1),
  localparam int SUM_W = $clog2(TARGET + WORD_W + 1),
  localparam int IDLE_W = $clog2(IDLE_CYCLES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] dataWord,
  input  logic              dataValid,
  input  seq_strobe_t       strobe,
  output logic              countDone,
  output logic              idleDone,
  output logic [CNT_W-1:0]  transCount
);
  logic              prevBit;
  logic [WORD_W-1:0] diffBits;
  logic [EDGE_W-1:0] edgeCnt;
  logic [SUM_W-1:0]  sumCnt;
  logic [IDLE_W-1:0] idleCnt;

  // Each serial bit is compared with the bit sent just before it.
  assign diffBits = dataWord ^ {dataWord[WORD_W-2:0], prevBit};

  always_comb begin
    edgeCnt = '0;
    for (int i = 0; i < WORD_W; i++) begin
      edgeCnt = edgeCnt + EDGE_W'(diffBits[i]);
    end
  end

  assign sumCnt    = SUM_W'(transCount) + SUM_W'(edgeCnt);
  assign countDone = strobe.countEn && (sumCnt >= SUM_W'(TARGET));
  assign idleDone  = strobe.idleEn && (idleCnt == IDLE_W'(IDLE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBit    <= 1'b0;
      transCount <= '0;
      idleCnt    <= '0;
    end else begin
      if (dataValid) prevBit <= dataWord[WORD_W-1];
      if (strobe.countEn) begin
        transCount <= countDone ? '0 : CNT_W'(sumCnt);
      end
      if (strobe.idleEn) begin
        idleCnt <= idleDone ? '0 : idleCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/align_lock_ctrl.sv
module align_lock_ctrl
  import align_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataValid,
  input  logic        calEn,
  input  logic        countDone,
  input  logic        idleDone,
  output seq_strobe_t strobe,
  output phase_e      phase
);
  phase_e phaseNext;
  logic   inTrain;
  logic   inQuiet;

  assign inTrain = (phase == PH_TRAIN0) || (phase == PH_TRAIN1) || (phase == PH_TRAIN2);
  assign inQuiet = (phase == PH_QUIET0) || (phase == PH_QUIET1);

  assign strobe.countEn = inTrain && dataValid;
  assign strobe.idleEn  = inQuiet;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_TRAIN0: if (countDone) phaseNext = calEn ? PH_QUIET0 : PH_LOCKED;
      PH_QUIET0: if (idleDone)  phaseNext = PH_TRAIN1;
      PH_TRAIN1: if (countDone) phaseNext = PH_QUIET1;
      PH_QUIET1: if (idleDone)  phaseNext = PH_TRAIN2;
      PH_TRAIN2: if (countDone) phaseNext = PH_LOCKED;
      PH_LOCKED: phaseNext = PH_LOCKED;
      default:   phaseNext = PH_TRAIN0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_TRAIN0;
    else       phase <= phaseNext;
  end
endmodule

// File: rtl/align_lock_seq.sv
module align_lock_seq
  import align_lock_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int TARGET = 256,
  parameter int IDLE_CYCLES = 96,
  localparam int CNT_W = $clog2(TARGET + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] dataWord,
  input  logic              dataValid,
  input  logic              calEn,
  output logic              locked,
  output logic [2:0]        phase,
  output logic [CNT_W-1:0]  transCount
);
  seq_strobe_t strobe;
  phase_e      phaseState;
  logic        countDone;
  logic        idleDone;

  align_lock_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dataValid (dataValid),
    .calEn     (calEn),
    .countDone (countDone),
    .idleDone  (idleDone),
    .strobe    (strobe),
    .phase     (phaseState)
  );

  align_lock_dp #(
    .WORD_W      (WORD_W),
    .TARGET      (TARGET),
    .IDLE_CYCLES (IDLE_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dataWord   (dataWord),
    .dataValid  (dataValid),
    .strobe     (strobe),
    .countDone  (countDone),
    .idleDone   (idleDone),
    .transCount (transCount)
  );

  assign phase  = phaseState;
  assign locked = (phaseState == PH_LOCKED);
endmodule

// File: rtl/align_lock_chk.sv
module align_lock_chk #(
  parameter int TARGET = 256,
  parameter int IDLE_CYCLES = 96,
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             dataValid,
  input logic             locked,
  input logic [2:0]       phase,
  input logic [CNT_W-1:0] transCount
);
  logic isQuiet;
  logic isTrain;
  int   quietRun;

  assign isQuiet = (phase == 3'd1) || (phase == 3'd3);
  assign isTrain = (phase == 3'd0) || (phase == 3'd2) || (phase == 3'd4);

  always_ff @(posedge clk) begin
    if (!rstN)        quietRun <= 0;
    else if (isQuiet) quietRun <= quietRun + 1;
    else              quietRun <= 0;
  end

  AST_COUNT_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rstN) int'(transCount) < TARGET); // R10
  AST_COUNT_ZERO_OFFPHASE: assert property (@(posedge clk) disable iff (!rstN) !isTrain |-> transCount == '0); // R10
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN) locked |=> locked); // R8
  AST_PHASE_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 3'd5) |=> (phase == $past(phase)) || (phase == $past(phase) + 3'd1) || ($past(phase) == 3'd0 && phase == 3'd5)); // R4
  AST_INVALID_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (isTrain && !dataValid) |=> $stable(transCount) && $stable(phase)); // R2
  AST_QUIET_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    (!isQuiet && quietRun != 0) |-> quietRun == IDLE_CYCLES); // R5
endmodule

bind align_lock_seq align_lock_chk #(
  .TARGET      (TARGET),
  .IDLE_CYCLES (IDLE_CYCLES),
  .CNT_W       (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dataValid  (dataValid),
  .locked     (locked),
  .phase      (phase),
  .transCount (transCount)
);

// File: tb/sim_align_lock_seq.sv
module sim_align_lock_seq;
  localparam int W = 10;
  localparam int TGT = 256;
  localparam int IDLE = 96;
  localparam int CW = $clog2(TGT + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  dataWord = '0;
  logic          dataValid = 1'b0;
  logic          calEn = 1'b0;
  logic          locked;
  logic [2:0]    phase;
  logic [CW-1:0] transCount;

  int checks = 0;
  int errors = 0;
  int cycNo = 0;

  // Behavioural reference
  int mPhase = 0, mCnt = 0, mIdle = 0;
  bit mPrev = 0;
  int sPos = 0;

  always #10 clk = ~clk;

  align_lock_seq #(.WORD_W(W), .TARGET(TGT), .IDLE_CYCLES(IDLE)) u0 (
    .clk(clk), .rstN(rstN), .dataWord(dataWord), .dataValid(dataValid),
    .calEn(calEn), .locked(locked), .phase(phase), .transCount(transCount)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycNo);
    end
  endtask

  task automatic modelStep(input logic [W-1:0] w, input logic v, input logic c);
    int e = 0;
    bit p = mPrev;
    for (int i = 0; i < W; i++) begin
      if (w[i] != p) e++;
      p = w[i];
    end
    if (mPhase == 0 || mPhase == 2 || mPhase == 4) begin
      if (v) begin
        if (mCnt + e >= TGT) begin
          mCnt = 0;
          if (mPhase == 0) mPhase = c ? 1 : 5;
          else if (mPhase == 2) mPhase = 3;
          else mPhase = 5;
        end else mCnt = mCnt + e;
      end
    end else if (mPhase == 1 || mPhase == 3) begin
      if (mIdle == IDLE - 1) begin
        mIdle = 0;
        mPhase = mPhase + 1;
      end else mIdle++;
    end
    if (v) mPrev = w[W-1];
  endtask

  task automatic compareAll();
    chk(int'(phase) == mPhase, "R4 phase", int'(phase), mPhase);
    chk(int'(transCount) == mCnt, "R1 transCount", int'(transCount), mCnt);
    chk(locked == (mPhase == 5), "R8 locked", int'(locked), int'(mPhase == 5));
  endtask

  task automatic cyc(input logic [W-1:0] w, input logic v, input logic c);
    @(negedge clk);
    dataWord = w; dataValid = v; calEn = c;
    @(posedge clk);
    modelStep(w, v, c);
    cycNo++;
    #5;
    compareAll();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; dataValid = 1'b0; dataWord = '0;
    repeat (2) @(posedge clk);
    #5;
    chk(locked == 1'b0, "R9 locked", int'(locked), 0);
    chk(phase == 3'd0, "R9 phase", int'(phase), 0);
    chk(transCount == '0, "R9 transCount", int'(transCount), 0);
    @(negedge clk);
    rstN = 1'b1;
    mPhase = 0; mCnt = 0; mIdle = 0; mPrev = 0; sPos = 0;
  endtask

  function automatic logic patBit(input int k, input int p);
    case (k)
      0: return (p % 20) >= 10;
      1: return (p % 8) >= 4;
      2: return ((p % 8) == 0) || ((p % 8) == 3);
      default: return (p % 2) == 0;
    endcase
  endfunction

  function automatic logic [W-1:0] nextWord(input int k);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[i] = patBit(k, sPos);
      sPos++;
    end
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int t1, t2;
    bit saw3, saw4;

    doReset();
    // R1: in-word and boundary transitions, LSB first, prev cleared to 0
    cyc(10'h001, 1, 0); chk(transCount == 2, "R1 first word", int'(transCount), 2);
    cyc(10'h000, 1, 0); chk(transCount == 2, "R1 quiet word", int'(transCount), 2);
    cyc(10'h200, 1, 0); chk(transCount == 3, "R1 top bit", int'(transCount), 3);
    cyc(10'h000, 1, 0); chk(transCount == 4, "R1 boundary", int'(transCount), 4);
    // R2: invalid word neither counts nor updates the last bit
    cyc(10'h3FF, 0, 0); chk(transCount == 4, "R2 invalid count", int'(transCount), 4);
    cyc(10'h000, 1, 0); chk(transCount == 4, "R2 last bit kept", int'(transCount), 4);

    // R3 / R6: alternating stream gives 10 per word, target crossed mid-word
    doReset();
    for (int i = 0; i < 25; i++) cyc(nextWord(3), 1, 0);
    chk(transCount == 250, "R6 before target", int'(transCount), 250);
    chk(phase == 3'd0, "R3 not yet locked", int'(phase), 0);
    cyc(nextWord(3), 1, 0);
    chk(phase == 3'd5, "R3 direct lock", int'(phase), 5);
    chk(transCount == 0, "R6 excess dropped", int'(transCount), 0);
    // R8: sticky under any data and calEn
    for (int i = 0; i < 20; i++) cyc(W'(i * 37), i[0], 1);
    chk(locked == 1'b1, "R8 sticky", int'(locked), 1);

    // R4 / R5 / R7: calibration sequence, calEn dropped after it is sampled
    doReset();
    t1 = -1; t2 = -1; saw3 = 0; saw4 = 0; n = 0;
    while (!locked && n < 3000) begin
      if (phase == 3'd1 || phase == 3'd3) cyc(W'(n * 91), n[1], 0);
      else cyc(nextWord(1), (n % 5) != 4, (t1 < 0));
      n++;
      if (phase == 3'd1 && t1 < 0) begin
        t1 = cycNo;
        chk(transCount == 0, "R10 zero in quiet", int'(transCount), 0);
      end
      if (phase == 3'd2 && t2 < 0) t2 = cycNo;
      if (phase == 3'd3) saw3 = 1;
      if (phase == 3'd4) saw4 = 1;
    end
    chk(t2 - t1 == IDLE, "R5 quiet length", t2 - t1, IDLE);
    chk(saw3 && saw4, "R4 full order", int'(saw3) + int'(saw4), 2);
    chk(locked == 1'b1, "R7 late calEn ignored", int'(locked), 1);

    // R7: calEn low when the first phase completes selects the plain path
    doReset();
    n = 0;
    while (phase == 3'd0 && n < 3000) begin
      cyc(nextWord(2), 1, (n < 10));
      n++;
    end
    chk(phase == 3'd5, "R7 plain path", int'(phase), 5);

    // R3: 10+10 pattern reaches 256 transitions on the 257th word
    doReset();
    n = 0;
    while (!locked && n < 3000) begin
      cyc(nextWord(0), 1, 0);
      n++;
    end
    chk(n == 257, "R3 lock word count", n, 257);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule